// File: doc/BRIEF.md
# Converter Clock-Ratio Detector and Startup Sequencer

This block brings the digital section of an oversampling audio converter out of power-down and puts it back there when clocking fails. It runs on a free-running reference clock. The master clock and the word clock reach it only as asynchronous levels, and each passes through a synchronizer and an edge detector. The first master-clock edge after power-down ends the idle state. On that edge the block reads a strap once, which chooses between generating the word clock itself and accepting the word clock from outside.

When it generates the word clock, the master-to-word ratio is fixed at 256. The generated word clock and the reference enable both start 127 master-clock edges into the wake-up. When it accepts the word clock from outside, it counts master edges over one word period and settles on 256, 384 or 512. An off-grid count is thrown away and the measurement runs again. In both cases the block then holds a settling interval of a set number of word periods. During that interval it forces the serial data line to a level that depends on the mode. After that it raises `run`.

If no master-clock edge arrives for a set number of reference cycles, the block drops back to power-down. In external-word-clock mode the same applies to the word clock. When the clocks return, the whole sequence runs again, including a new ratio measurement.

Top module: `conv_startup_seq`

## Requirements
- R1: After reset, and in power-down, every output is 0. The block stays in power-down until it observes a rising master-clock edge.
- R2: The strap is read only on the master edge that ends power-down. `strap_master`=1 selects internal word-clock generation (`is_slave`=0) and 0 selects an external word clock (`is_slave`=1). The choice holds until the next power-down, and later strap changes have no effect.
- R3: In internal mode `ratio_sel` is code 1 (256). `word_clk_oe` and `ref_en` rise together at the 127th master rising edge after the edge that ended power-down. `word_clk_out` starts high and has a period of 256 master rising edges.
- R4: In external mode the block counts master rising edges between consecutive word-clock rising edges. A count within ±8 of 256, 384 or 512 gives `ratio_sel` code 1, 2 or 3. Any other count is rejected: measuring goes on with the next word period, `ratio_sel` stays 0 and `ref_en` stays low.
- R5: `ref_en` rises when word-clock generation starts (internal mode) or when a ratio is accepted (external mode). Whenever `ref_en` is high, `ratio_sel` is nonzero.
- R6: `force_en` is high from the mode decision until SETTLE_PERIODS word periods have passed after `ref_en` rises. `force_val` is 0 in internal mode and 1 in external mode. `run` rises in the same cycle that `force_en` falls.
- R7: If no master-clock edge is seen for MCLK_LOSS (64) reference cycles, the block enters power-down. In external mode, once a word edge has been seen in the current sequence, WCLK_LOSS reference cycles without a word edge also cause power-down.
- R8: After a power-down caused by clock loss, the returning clocks restart the full sequence, including the strap read and a new ratio measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mclk_in | input | 1 | Asynchronous master clock level |
| wclk_in | input | 1 | Asynchronous external word clock level |
| strap_master | input | 1 | Mode strap, 1 = generate word clock internally |
| is_slave | output | 1 | External word-clock mode selected |
| ratio_sel | output | 2 | Ratio code: 0 none, 1 = 256, 2 = 384, 3 = 512 |
| ref_en | output | 1 | Enable for the analog reference |
| force_en | output | 1 | Data line is forced to `force_val` |
| force_val | output | 1 | Level of the forced data line |
| run | output | 1 | Settling finished, normal conversion |
| word_clk_out | output | 1 | Generated word clock (internal mode) |
| word_clk_oe | output | 1 | Drive enable for the generated word clock |

## Verification
A corrupted state register, or a settle or wake counter that is off by one, shows up at the ports as a shift in the master or word edge on which `ref_en` or `run` rises. A wrong measured ratio shows up as a wrong `ratio_sel` code one word period after the bad count. A stuck loss timer either keeps `ref_en` high after the clocks stop or drops it while the clocks are still running, within tens of reference cycles for the master clock. Every change of the six status outputs is compared in order against an expected sequence. A spurious extra transition, such as a mode flip after a strap change, is therefore caught at the cycle where it happens.

// File: rtl/css_pkg.sv
package css_pkg;

    localparam int CNT_W = 10;

    typedef enum logic [1:0] {
        RATIO_NONE = 2'd0,
        RATIO_256  = 2'd1,
        RATIO_384  = 2'd2,
        RATIO_512  = 2'd3
    } ratio_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_WAKE,
        ST_MEAS,
        ST_SETTLE,
        ST_RUN
    } seq_state_e;

    function automatic ratio_e classify_count(input logic [CNT_W-1:0] c, input int tol);
        int v;
        v = int'(c);
        if (v >= 256 - tol && v <= 256 + tol) return RATIO_256;
        if (v >= 384 - tol && v <= 384 + tol) return RATIO_384;
        if (v >= 512 - tol && v <= 512 + tol) return RATIO_512;
        return RATIO_NONE;
    endfunction

endpackage

// File: rtl/css_clk_watch.sv
module css_clk_watch #(
    parameter int LIMIT  = 64,
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise,
    output logic lost
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;
    logic [CW-1:0]     idle_q;
    logic              level;

    assign level = sync_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            idle_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            prev_q <= level;
            if (level != prev_q)
                idle_q <= '0;
            else if (idle_q != LIM_V)
                idle_q <= idle_q + 1'b1;
        end
    end

    assign rise = level & ~prev_q;
    assign lost = (idle_q == LIM_V);
endmodule

// File: rtl/css_ratio_meter.sv
module css_ratio_meter
    import css_pkg::*;
#(
    parameter int TOL = 8
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clear,
    input  logic   m_rise,
    input  logic   w_rise,
    output logic   armed,
    output logic   done,
    output ratio_e code
);
    logic [CNT_W-1:0] cnt_q;
    ratio_e           verdict;

    assign verdict = classify_count(cnt_q, TOL);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            armed <= 1'b0;
            done  <= 1'b0;
            cnt_q <= '0;
            code  <= RATIO_NONE;
        end else begin
            done <= 1'b0;
            if (w_rise) begin
                armed <= 1'b1;
                cnt_q <= m_rise ? CNT_W'(1) : '0;
                if (armed && verdict != RATIO_NONE) begin
                    done <= 1'b1;
                    code <= verdict;
                end
            end else if (m_rise && cnt_q != '1) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/css_sequencer.sv
module css_sequencer
    import css_pkg::*;
#(
    parameter int SETTLE_PERIODS = 11265,
    parameter int WAKE_EDGES     = 127,
    parameter int M_RATIO        = 256
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   strap_master,
    input  logic   m_rise,
    input  logic   w_rise,
    input  logic   m_lost,
    input  logic   w_lost,
    input  logic   meas_armed,
    input  logic   meas_done,
    input  ratio_e meas_code,
    output logic   in_meas,
    output logic   is_slave,
    output logic [1:0] ratio_sel,
    output logic   ref_en,
    output logic   force_en,
    output logic   force_val,
    output logic   run,
    output logic   word_clk_out,
    output logic   word_clk_oe
);
    localparam int SC_W = $clog2(SETTLE_PERIODS + 1);
    localparam int WK_W = $clog2(WAKE_EDGES + 1);
    localparam int GN_W = $clog2(M_RATIO);
    localparam logic [SC_W-1:0] SETTLE_LAST = SC_W'(SETTLE_PERIODS - 1);
    localparam logic [WK_W-1:0] WAKE_LAST   = WK_W'(WAKE_EDGES - 1);
    localparam logic [GN_W-1:0] GEN_LAST    = GN_W'(M_RATIO - 1);
    localparam logic [GN_W-1:0] GEN_HALF    = GN_W'(M_RATIO / 2);

    seq_state_e      st_q;
    logic            slave_q;
    ratio_e          ratio_q;
    logic [WK_W-1:0] wake_q;
    logic [SC_W-1:0] settle_q;
    logic [GN_W-1:0] gen_q;
    logic            gen_on_q;
    logic            w_watch;
    logic            drop;
    logic            tick;

    assign w_watch = (st_q == ST_SETTLE) || (st_q == ST_RUN) ||
                     ((st_q == ST_MEAS) && meas_armed);
    assign drop    = (st_q != ST_OFF) && (m_lost || (slave_q && w_watch && w_lost));
    assign tick    = slave_q ? w_rise : (gen_on_q && m_rise && gen_q == GEN_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_OFF;
            slave_q  <= 1'b0;
            ratio_q  <= RATIO_NONE;
            wake_q   <= '0;
            settle_q <= '0;
            gen_q    <= '0;
            gen_on_q <= 1'b0;
        end else if (drop) begin
            st_q     <= ST_OFF;
            slave_q  <= 1'b0;
            ratio_q  <= RATIO_NONE;
            gen_on_q <= 1'b0;
            gen_q    <= '0;
        end else begin
            if (gen_on_q && m_rise)
                gen_q <= (gen_q == GEN_LAST) ? '0 : gen_q + 1'b1;
            unique case (st_q)
                ST_OFF: begin
                    if (m_rise) begin
                        slave_q <= ~strap_master;
                        wake_q  <= '0;
                        if (strap_master) begin
                            ratio_q <= RATIO_256;
                            st_q    <= ST_WAKE;
                        end else begin
                            st_q    <= ST_MEAS;
                        end
                    end
                end
                ST_WAKE: begin
                    if (m_rise) begin
                        if (wake_q == WAKE_LAST) begin
                            gen_on_q <= 1'b1;
                            gen_q    <= '0;
                            settle_q <= '0;
                            st_q     <= ST_SETTLE;
                        end else begin
                            wake_q <= wake_q + 1'b1;
                        end
                    end
                end
                ST_MEAS: begin
                    if (meas_done) begin
                        ratio_q  <= meas_code;
                        settle_q <= '0;
                        st_q     <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (tick) begin
                        if (settle_q == SETTLE_LAST)
                            st_q <= ST_RUN;
                        else
                            settle_q <= settle_q + 1'b1;
                    end
                end
                ST_RUN: ;
                default: st_q <= ST_OFF;
            endcase
        end
    end

    assign in_meas      = (st_q == ST_MEAS);
    assign is_slave     = slave_q;
    assign ratio_sel    = ratio_q;
    assign ref_en       = (st_q == ST_SETTLE) || (st_q == ST_RUN);
    assign force_en     = (st_q == ST_WAKE) || (st_q == ST_MEAS) || (st_q == ST_SETTLE);
    assign force_val    = slave_q;
    assign run          = (st_q == ST_RUN);
    assign word_clk_oe  = gen_on_q;
    assign word_clk_out = gen_on_q && (gen_q < GEN_HALF);
endmodule

// File: rtl/conv_startup_seq.sv
module conv_startup_seq
    import css_pkg::*;
#(
    parameter int SETTLE_PERIODS = 11265,
    parameter int WAKE_EDGES     = 127,
    parameter int M_RATIO        = 256,
    parameter int MCLK_LOSS      = 64,
    parameter int WCLK_LOSS      = 4096,
    parameter int RATIO_TOL      = 8,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mclk_in,
    input  logic       wclk_in,
    input  logic       strap_master,
    output logic       is_slave,
    output logic [1:0] ratio_sel,
    output logic       ref_en,
    output logic       force_en,
    output logic       force_val,
    output logic       run,
    output logic       word_clk_out,
    output logic       word_clk_oe
);
    localparam int NCLK = 2;

    logic [NCLK-1:0] raw_clk;
    logic [NCLK-1:0] mon_rise;
    logic [NCLK-1:0] mon_lost;
    logic            in_meas;
    logic            meas_armed;
    logic            meas_done;
    ratio_e          meas_code;

    assign raw_clk = {wclk_in, mclk_in};

    for (genvar g = 0; g < NCLK; g++) begin : g_watch
        localparam int LIM = (g == 0) ? MCLK_LOSS : WCLK_LOSS;
        css_clk_watch #(.LIMIT(LIM), .STAGES(SYNC_STAGES)) u_watch (
            .clk      (clk),
            .rst      (rst),
            .async_in (raw_clk[g]),
            .rise     (mon_rise[g]),
            .lost     (mon_lost[g])
        );
    end

    css_ratio_meter #(.TOL(RATIO_TOL)) u_meter (
        .clk    (clk),
        .rst    (rst),
        .clear  (~in_meas),
        .m_rise (mon_rise[0]),
        .w_rise (mon_rise[1]),
        .armed  (meas_armed),
        .done   (meas_done),
        .code   (meas_code)
    );

    css_sequencer #(
        .SETTLE_PERIODS (SETTLE_PERIODS),
        .WAKE_EDGES     (WAKE_EDGES),
        .M_RATIO        (M_RATIO)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .strap_master (strap_master),
        .m_rise       (mon_rise[0]),
        .w_rise       (mon_rise[1]),
        .m_lost       (mon_lost[0]),
        .w_lost       (mon_lost[1]),
        .meas_armed   (meas_armed),
        .meas_done    (meas_done),
        .meas_code    (meas_code),
        .in_meas      (in_meas),
        .is_slave     (is_slave),
        .ratio_sel    (ratio_sel),
        .ref_en       (ref_en),
        .force_en     (force_en),
        .force_val    (force_val),
        .run          (run),
        .word_clk_out (word_clk_out),
        .word_clk_oe  (word_clk_oe)
    );
endmodule

// File: rtl/css_checker.sv
module css_checker (
    input logic       clk,
    input logic       rst,
    input logic       is_slave,
    input logic [1:0] ratio_sel,
    input logic       ref_en,
    input logic       force_en,
    input logic       run,
    input logic       m_lost
);
    logic active;
    assign active = ref_en | force_en | run;

    assert_refen_ratio_R5: assert property (@(posedge clk) disable iff (rst)
        ref_en |-> ratio_sel != 2'd0);

    assert_internal_256_R3: assert property (@(posedge clk) disable iff (rst)
        (ratio_sel != 2'd0 && !is_slave) |-> ratio_sel == 2'd1);

    assert_mode_held_R2: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> $stable(is_slave));

    assert_run_after_settle_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> ($past(force_en) && $past(ref_en)));

    assert_mclk_loss_off_R7: assert property (@(posedge clk) disable iff (rst)
        (m_lost && active) |=> (!ref_en && !force_en && !run));
endmodule

bind conv_startup_seq css_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .is_slave  (is_slave),
    .ratio_sel (ratio_sel),
    .ref_en    (ref_en),
    .force_en  (force_en),
    .run       (run),
    .m_lost    (mon_lost[0])
);

// File: tb/sim_conv_startup_seq.sv
module sim_conv_startup_seq;
    localparam int SETTLE = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mclk = 1'b0;
    logic wclk = 1'b0;
    logic strap_master = 1'b0;
    logic is_slave, ref_en, force_en, force_val, run, word_clk_out, word_clk_oe;
    logic [1:0] ratio_sel;

    bit mclk_on = 1'b0;
    bit wclk_on = 1'b0;
    int bench_ratio = 256;
    int mcount = 0;
    int wcount = 0;
    int wcnt = 0;
    int checks = 0;
    int fails = 0;

    logic [6:0] exp_q[$];
    string      tag_q[$];
    logic [6:0] last_snap = '0;
    logic [6:0] exp_v;
    string      exp_t;
    logic [6:0] snap;

    conv_startup_seq #(.SETTLE_PERIODS(SETTLE)) u0 (
        .clk(clk), .rst(rst), .mclk_in(mclk), .wclk_in(wclk),
        .strap_master(strap_master), .is_slave(is_slave), .ratio_sel(ratio_sel),
        .ref_en(ref_en), .force_en(force_en), .force_val(force_val), .run(run),
        .word_clk_out(word_clk_out), .word_clk_oe(word_clk_oe)
    );

    // {is_slave, ratio_sel[1:0], ref_en, force_en, force_val, run}
    assign snap = {is_slave, ratio_sel, ref_en, force_en, force_val, run};

    always #5 clk = ~clk;

    initial forever begin
        #30;
        if (mclk_on) mclk = ~mclk;
    end

    always @(posedge mclk) begin
        mcount <= mcount + 1;
        if (wclk_on) begin
            if (wcnt >= bench_ratio / 2 - 1) begin
                wcnt <= 0;
                wclk <= ~wclk;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    always @(posedge wclk) wcount <= wcount + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [6:0] s, input string t);
        exp_q.push_back(s);
        tag_q.push_back(t);
    endtask

    // monitor: every output change must match the next expected item
    always @(negedge clk) begin
        if (!rst && snap !== last_snap) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected change (R2/R7) actual=%b expected=%b", snap, last_snap);
            end else begin
                exp_v = exp_q.pop_front();
                exp_t = tag_q.pop_front();
                if (snap !== exp_v) begin
                    fails++;
                    $display("FAIL %s actual=%b expected=%b", exp_t, snap, exp_v);
                end
            end
            last_snap = snap;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int base;
        int diff;
        int cyc;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(snap == 7'd0, "R1 reset state", int'(snap), 0);
        check(word_clk_oe == 1'b0, "R1 word clock not driven", int'(word_clk_oe), 0);
        repeat (200) @(negedge clk);
        check(snap == 7'd0, "R1 idle without master clock", int'(snap), 0);

        // internal word clock mode
        strap_master = 1'b1;
        push(7'b0010100, "R2 internal mode decision");
        push(7'b0011100, "R5 reference enable internal");
        push(7'b0011001, "R6 run internal");
        base = mcount;
        mclk_on = 1'b1;
        wait (ref_en);
        diff = mcount - base;
        check(diff >= 127 && diff <= 129, "R3 wake edge count", diff, 128);
        @(negedge clk);
        check(word_clk_oe && word_clk_out, "R3 word clock starts high", int'({word_clk_oe, word_clk_out}), 3);
        base = mcount;
        strap_master = 1'b0;
        wait (run);
        diff = mcount - base;
        check(diff >= 767 && diff <= 769, "R6 internal settle length", diff, 768);
        @(negedge clk);
        check(is_slave == 1'b0, "R2 late strap change ignored", int'(is_slave), 0);
        @(posedge word_clk_out);
        base = mcount;
        @(posedge word_clk_out);
        diff = mcount - base;
        check(diff >= 255 && diff <= 257, "R3 word clock period", diff, 256);

        // master clock loss
        push(7'd0, "R7 master clock loss internal");
        mclk_on = 1'b0;
        cyc = 0;
        while (ref_en && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc >= 55 && cyc <= 80, "R7 loss detection delay", cyc, 67);
        check(word_clk_oe == 1'b0, "R7 word clock released", int'(word_clk_oe), 0);

        // external mode, off-grid ratio first
        bench_ratio = 300;
        wclk_on = 1'b1;
        push(7'b1000110, "R2 external mode decision");
        mclk_on = 1'b1;
        repeat (9000) @(negedge clk);
        check(ref_en == 1'b0, "R4 off-grid ratio rejected", int'(ref_en), 0);
        check(ratio_sel == 2'd0, "R4 no ratio for off-grid count", int'(ratio_sel), 0);
        push(7'b1101110, "R4 ratio 384 accepted");
        push(7'b1101011, "R6 run external");
        bench_ratio = 384;
        wait (ref_en);
        base = wcount;
        wait (run);
        diff = wcount - base;
        check(diff == SETTLE, "R6 external settle length", diff, SETTLE);

        // word clock loss, then restart with a new ratio
        push(7'd0, "R7 word clock loss");
        push(7'b1000110, "R8 restart measuring");
        wclk_on = 1'b0;
        wait (!ref_en);
        repeat (20) @(negedge clk);
        check(is_slave && !ref_en, "R8 waiting for word clock", int'({is_slave, ref_en}), 2);
        push(7'b1111110, "R8 fresh ratio 512");
        push(7'b1111011, "R8 run after restart");
        bench_ratio = 512;
        wclk_on = 1'b1;
        wait (run);
        @(negedge clk);
        check(ratio_sel == 2'd3, "R8 fresh measurement code", int'(ratio_sel), 3);

        // master clock loss in external mode
        push(7'd0, "R7 master clock loss external");
        mclk_on = 1'b0;
        wait (!ref_en);
        repeat (200) @(negedge clk);
        check(snap == 7'd0, "R7 power-down outputs", int'(snap), 0);
        check(exp_q.size() == 0, "R1 all expected transitions seen", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule